// File: doc/BRIEF.md
# Float-to-Integer Converter with Selectable Overflow Policy

This block turns a binary floating-point value, presented in the 64-bit register layout (a double, or a single held in double layout), into a signed or unsigned integer of 32 or 64 bits. The caller picks the target type, a 3-bit conversion mode, the rounding field of the floating-point status, and whether invalid exceptions are enabled. One cycle after `in_valid`, the block returns the 64-bit integer, the exception flags, an overflow hint for the overflow-enabled instruction variant, and a write enable for the destination.

The conversion mode does two things. Its low bit forces truncation. Its upper bits pick how values that do not fit are handled. One policy clamps and sends NaN to the most negative value. A second clamps and sends NaN to zero. The third wraps, keeping the low bits of the exact integer. Two mode codes are reserved and reported as illegal. Trap delivery, the status register and instruction decode live outside the block.

Top module: `f2i_convert`

## Requirements
- R1: `int_kind` selects the target: 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit, 3 = unsigned 64-bit. A signed 32-bit result is sign-extended from bit 31 into `int_result[63:32]`, and an unsigned 32-bit result is zero-extended.
- R2: When `cvt_mode[0]` is 1, the value is truncated toward zero. When it is 0, `status_rnd` selects the rounding: 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity.
- R3: Modes 0 and 1 saturate, and NaN gives the minimum of the type. The limits are 0xFFFFFFFF80000000 and 0x7FFFFFFF for signed 32-bit, 0 and 0xFFFFFFFF for unsigned 32-bit, 0x8000000000000000 and 0x7FFFFFFFFFFFFFFF for signed 64-bit, and 0 and all-ones for unsigned 64-bit.
- R4: Modes 2 and 3 saturate with the same limits, but NaN gives zero.
- R5: Modes 4 and 5 wrap. Infinity and NaN give zero. Any other value gives the low 32 or 64 bits of the exact rounded two's-complement integer, which is then extended as in R1.
- R6: Modes 6 and 7 raise `illegal_op`. In that case `wr_en` is 0 and every flag and `ovf_hit` is 0.
- R7: `flag_snan` is set for a NaN whose fraction bit 51 is 0. `flag_badcvt` is set in every legal mode for NaN, for infinity, and for a rounded value outside the type's range.
- R8: `flag_inexact` is set when the value is in range and the rounded integer differs from the source. `flag_fr` is set when, in addition, rounding increased the magnitude.
- R9: When `flag_badcvt` is set and `inv_trap_en` is 1, `wr_en` is 0 and both `flag_inexact` and `flag_fr` are 0.
- R10: `ovf_hit` is set when the source is NaN or infinity, out of range, or not an integer. It is forced to 0 whenever the write is suppressed.
- R11: When `src_single` is 1, fraction bits 28..0 of `src_bits` are ignored, because the source is a single held in double layout.
- R12: Outputs are registered. `out_valid` follows `in_valid` one cycle later. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| src_bits | input | 64 | Floating-point source in double layout |
| src_single | input | 1 | Source is a single in double layout |
| int_kind | input | 2 | Target integer type |
| cvt_mode | input | 3 | Conversion mode |
| status_rnd | input | 2 | Rounding field of the FP status |
| inv_trap_en | input | 1 | Invalid exceptions enabled |
| out_valid | output | 1 | Result present |
| int_result | output | 64 | Integer result |
| wr_en | output | 1 | Destination write enable |
| illegal_op | output | 1 | Reserved mode used |
| flag_snan | output | 1 | Invalid: signalling NaN |
| flag_badcvt | output | 1 | Invalid conversion |
| flag_inexact | output | 1 | Inexact result |
| flag_fr | output | 1 | Fraction rounded up |
| ovf_hit | output | 1 | Integer overflow condition for the overflow-enabled variant |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing;
- the extension of 32-bit results;
- that an illegal mode never writes and raises no flag;
- how the flags imply one another (signalling NaN implies invalid, fraction-rounded implies inexact, inexact implies overflow);
- that a trapped invalid clears the rounding flags.

The actual integer values can only be shown by the bench's scenarios: the rounding direction, the clamp limits, the NaN value chosen per policy, and the wrapped low bits. So can the precise onset of out-of-range at each type's edges, and the masking of low fraction bits in single mode.

// File: rtl/f2i_convert.sv
module f2i_convert (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] src_bits,
  input  logic        src_single,
  input  logic [1:0]  int_kind,
  input  logic [2:0]  cvt_mode,
  input  logic [1:0]  status_rnd,
  input  logic        inv_trap_en,
  output logic        out_valid,
  output logic [63:0] int_result,
  output logic        wr_en,
  output logic        illegal_op,
  output logic        flag_snan,
  output logic        flag_badcvt,
  output logic        flag_inexact,
  output logic        flag_fr,
  output logic        ovf_hit
);
  localparam logic [11:0] BIAS_INT = 12'd1075;

  logic [63:0] b;
  logic        sgn, is_nan, is_inf, is_snan;
  logic [10:0] ex;
  logic [51:0] fr;
  logic [52:0] mant;
  logic [11:0] eeff, lsh, rsh;
  logic        left, huge, far, guard, stick, lost, inc, trunc;
  logic [116:0] ext;
  logic [127:0] mag, rmag, exact, pos_lim, neg_lim;
  logic        too_hi, too_lo;
  logic [63:0] vmin, vmax, low64, sat_res, wrap_res, raw;

  assign b       = src_single ? {src_bits[63:29], 29'b0} : src_bits;
  assign sgn     = b[63];
  assign ex      = b[62:52];
  assign fr      = b[51:0];
  assign is_nan  = (&ex) & (|fr);
  assign is_inf  = (&ex) & ~(|fr);
  assign is_snan = is_nan & ~fr[51];
  assign mant    = {|ex, fr};
  assign eeff    = {1'b0, (ex == 11'd0) ? 11'd1 : ex};
  assign left    = eeff >= BIAS_INT;
  assign lsh     = eeff - BIAS_INT;
  assign rsh     = BIAS_INT - eeff;
  assign huge    = left & (lsh > 12'd74);
  assign far     = ~left & (rsh > 12'd64);
  assign trunc   = cvt_mode[0] | (status_rnd == 2'b01);

  always_comb begin
    ext   = {mant, 64'b0} >> rsh[6:0];
    guard = 1'b0;
    stick = 1'b0;
    mag   = '0;
    if (left) begin
      if (!huge) mag = {75'b0, mant} << lsh[6:0];
    end else if (far) begin
      stick = |mant;
    end else begin
      mag   = {75'b0, ext[116:64]};
      guard = ext[63];
      stick = |ext[62:0];
    end
  end

  assign lost = guard | stick;

  always_comb begin
    inc = 1'b0;
    if (!trunc) begin
      case (status_rnd)
        2'b00:   inc = guard & (stick | mag[0]);
        2'b10:   inc = ~sgn & lost;
        2'b11:   inc = sgn & lost;
        default: inc = 1'b0;
      endcase
    end
  end

  assign rmag  = mag + {127'b0, inc};
  assign exact = sgn ? -rmag : rmag;
  assign low64 = exact[63:0];

  always_comb begin
    case (int_kind)
      2'd0: begin
        pos_lim = 128'h7FFF_FFFF;         neg_lim = 128'h8000_0000;
        vmin = 64'hFFFF_FFFF_8000_0000;   vmax = 64'h0000_0000_7FFF_FFFF;
      end
      2'd1: begin
        pos_lim = 128'hFFFF_FFFF;         neg_lim = '0;
        vmin = '0;                        vmax = 64'h0000_0000_FFFF_FFFF;
      end
      2'd2: begin
        pos_lim = 128'h7FFF_FFFF_FFFF_FFFF; neg_lim = 128'h8000_0000_0000_0000;
        vmin = 64'h8000_0000_0000_0000;     vmax = 64'h7FFF_FFFF_FFFF_FFFF;
      end
      default: begin
        pos_lim = 128'hFFFF_FFFF_FFFF_FFFF; neg_lim = '0;
        vmin = '0;                          vmax = '1;
      end
    endcase
  end

  assign too_hi = ~is_nan & ~sgn & (huge | (rmag > pos_lim));
  assign too_lo = ~is_nan &  sgn & (huge | (rmag > neg_lim));

  assign sat_res  = is_nan ? (cvt_mode[1] ? 64'd0 : vmin) :
                    too_hi ? vmax : too_lo ? vmin : low64;
  assign wrap_res = (is_nan | is_inf) ? 64'd0 : low64;
  assign raw      = cvt_mode[2] ? wrap_res : sat_res;

  logic        ill, bad, trap;
  logic [63:0] fin;
  assign ill  = cvt_mode[2] & cvt_mode[1];
  assign bad  = ~ill & (is_nan | too_hi | too_lo);
  assign trap = bad & inv_trap_en;
  assign fin  = (int_kind == 2'd0) ? {{32{raw[31]}}, raw[31:0]} :
                (int_kind == 2'd1) ? {32'b0, raw[31:0]} : raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      int_result   <= '0;
      wr_en        <= 1'b0;
      illegal_op   <= 1'b0;
      flag_snan    <= 1'b0;
      flag_badcvt  <= 1'b0;
      flag_inexact <= 1'b0;
      flag_fr      <= 1'b0;
      ovf_hit      <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      int_result   <= fin;
      wr_en        <= in_valid & ~ill & ~trap;
      illegal_op   <= in_valid & ill;
      flag_snan    <= in_valid & ~ill & is_snan;
      flag_badcvt  <= in_valid & bad;
      flag_inexact <= in_valid & ~ill & ~bad & lost;
      flag_fr      <= in_valid & ~ill & ~bad & inc;
      ovf_hit      <= in_valid & ~ill & ~trap & (bad | lost);
    end
  end
endmodule

module f2i_convert_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  int_kind,
  input logic [2:0]  cvt_mode,
  input logic        out_valid,
  input logic [32:0] res_hi,
  input logic        wr_en,
  input logic        illegal_op,
  input logic        flag_snan,
  input logic        flag_badcvt,
  input logic        flag_inexact,
  input logic        flag_fr,
  input logic        ovf_hit
);
  assert_valid_lat_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_sext_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && int_kind == 2'd0 && cvt_mode[2:1] != 2'b11 |=> res_hi[32:1] == {32{res_hi[0]}});
  assert_zext_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && int_kind == 2'd1 && cvt_mode[2:1] != 2'b11 |=> res_hi[32:1] == 32'd0);
  assert_illegal_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && illegal_op |-> !wr_en && !flag_badcvt && !flag_snan && !flag_inexact && !ovf_hit);
  assert_snan_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flag_snan |-> flag_badcvt);
  assert_fr_inexact_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flag_fr |-> flag_inexact);
  assert_trap_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flag_badcvt && !wr_en |-> !flag_inexact && !flag_fr && !ovf_hit);
  assert_inexact_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flag_inexact |-> ovf_hit);
endmodule

bind f2i_convert f2i_convert_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .int_kind(int_kind),
  .cvt_mode(cvt_mode), .out_valid(out_valid), .res_hi(int_result[63:31]),
  .wr_en(wr_en), .illegal_op(illegal_op), .flag_snan(flag_snan),
  .flag_badcvt(flag_badcvt), .flag_inexact(flag_inexact), .flag_fr(flag_fr),
  .ovf_hit(ovf_hit)
);

// File: tb/tb_f2i_convert.sv
module tb_f2i_convert;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] src_bits = '0;
  logic        src_single = 1'b0;
  logic [1:0]  int_kind = '0;
  logic [2:0]  cvt_mode = '0;
  logic [1:0]  status_rnd = '0;
  logic        inv_trap_en = 1'b0;
  logic        out_valid, wr_en, illegal_op, flag_snan, flag_badcvt, flag_inexact, flag_fr, ovf_hit;
  logic [63:0] int_result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  f2i_convert dut (.*);

  task automatic check(input string tag, input logic [70:0] got, input logic [70:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // expected {result, wr_en, illegal, snan, badcvt, inexact, fr, ovf}
  function automatic logic [70:0] model(input logic [63:0] raw_in, input logic sgl,
      input logic [1:0] k, input logic [2:0] m, input logic [1:0] rm, input logic ie);
    logic [63:0] b; logic s, nan, inf, snan, huge, lost, up, oor, ill, bad, trap;
    logic [10:0] e; logic [127:0] mg, val, posmax, negmax;
    logic [63:0] lo, mn, mx, r;
    real ax, fl, fp; longint li;
    b = sgl ? {raw_in[63:29], 29'b0} : raw_in;
    s = b[63]; e = b[62:52];
    nan = (e == 11'h7FF) && (b[51:0] != 0);
    inf = (e == 11'h7FF) && (b[51:0] == 0);
    snan = nan && !b[51];
    huge = 0; lost = 0; up = 0; mg = '0;
    if (e >= 11'd1075) begin
      if (e - 11'd1075 > 11'd74) huge = 1;
      else mg = {75'b0, 1'b1, b[51:0]} << (e - 11'd1075);
    end else begin
      ax = $bitstoreal(b);
      if (ax < 0.0) ax = -ax;
      fl = $floor(ax); fp = ax - fl; li = longint'(fl);
      lost = (fp != 0.0);
      if (!(m[0] || rm == 2'b01))
        case (rm)
          2'b00: up = (fp > 0.5) || (fp == 0.5 && li[0]);
          2'b10: up = !s && lost;
          2'b11: up = s && lost;
          default: up = 0;
        endcase
      mg = 128'(li) + 128'(up);
    end
    case (k)
      2'd0: begin posmax = 128'd2147483647; negmax = 128'd2147483648; mn = 64'hFFFFFFFF80000000; mx = 64'h7FFFFFFF; end
      2'd1: begin posmax = 128'd4294967295; negmax = 0; mn = 0; mx = 64'hFFFFFFFF; end
      2'd2: begin posmax = {65'b0, {63{1'b1}}}; negmax = {64'b0, 1'b1, 63'b0}; mn = {1'b1, 63'b0}; mx = {1'b0, {63{1'b1}}}; end
      default: begin posmax = {64'b0, {64{1'b1}}}; negmax = 0; mn = 0; mx = '1; end
    endcase
    oor = !nan && (huge || (s ? (mg > negmax) : (mg > posmax)));
    val = s ? (128'd0 - mg) : mg;
    lo = val[63:0];
    if (m[2]) r = (nan || inf) ? 64'd0 : lo;
    else if (nan) r = m[1] ? 64'd0 : mn;
    else if (oor) r = s ? mn : mx;
    else r = lo;
    if (k == 2'd0) r = {{32{r[31]}}, r[31:0]};
    else if (k == 2'd1) r = {32'b0, r[31:0]};
    ill = m[2] && m[1];
    bad = !ill && (nan || oor);
    trap = bad && ie;
    return {r, !ill && !trap, ill, !ill && snan, bad, !ill && !bad && lost,
            !ill && !bad && up, !ill && !trap && (bad || lost)};
  endfunction

  task automatic run(input string tag, input logic [63:0] v, input logic sgl, input logic [1:0] k,
      input logic [2:0] m, input logic [1:0] rm, input logic ie);
    @(negedge clk);
    src_bits = v; src_single = sgl; int_kind = k; cvt_mode = m; status_rnd = rm; inv_trap_en = ie;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (!out_valid) begin checks++; errors++; $display("FAIL R12: out_valid actual=0 expected=1"); end
    check(tag, {int_result, wr_en, illegal_op, flag_snan, flag_badcvt, flag_inexact, flag_fr, ovf_hit},
          model(v, sgl, k, m, rm, ie));
  endtask

  task automatic lit(input string tag, input logic [63:0] exp);
    check(tag, {7'b0, int_result}, {7'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset", {int_result, wr_en, illegal_op, flag_snan, flag_badcvt, flag_inexact, flag_fr, out_valid}, '0);
    rst_n = 1'b1;
    // R2 rounding directions on 2.5, 3.5, -1.5
    run("R2 rne 2.5", 64'h4004000000000000, 0, 2, 0, 2'b00, 0); lit("R2 rne 2.5 lit", 64'd2);
    run("R2 rne 3.5", 64'h400C000000000000, 0, 2, 0, 2'b00, 0); lit("R2 rne 3.5 lit", 64'd4);
    run("R2 floor -1.5", 64'hBFF8000000000000, 0, 2, 0, 2'b11, 0); lit("R2 floor lit", 64'hFFFFFFFFFFFFFFFE);
    run("R2 ceil -1.5", 64'hBFF8000000000000, 0, 2, 0, 2'b10, 0);
    run("R2 odd mode truncs", 64'h400C000000000000, 0, 2, 3, 2'b10, 0); lit("R2 trunc lit", 64'd3);
    // R3/R4 NaN and saturation
    run("R3 snan min", 64'h7FF0000000000001, 0, 0, 0, 0, 0); lit("R3 snan lit", 64'hFFFFFFFF80000000);
    run("R4 qnan zero", 64'h7FF8000000000000, 0, 2, 2, 0, 0); lit("R4 qnan lit", 64'd0);
    run("R3 2^31 s32 sat", 64'h41E0000000000000, 0, 0, 1, 0, 0); lit("R3 sat lit", 64'h7FFFFFFF);
    run("R3 -1 u32 sat", 64'hBFF0000000000000, 0, 1, 1, 0, 0);
    run("R3 2^64 u64 sat", 64'h43F0000000000000, 0, 3, 0, 0, 0);
    run("R3 -2^63 s64 edge", 64'hC3E0000000000000, 0, 2, 0, 0, 0);
    run("R4 -inf u64", 64'hFFF0000000000000, 0, 3, 3, 0, 0);
    // R5 wrap
    run("R5 wrap 2^32+5", 64'h41F0000000500000, 0, 0, 5, 0, 0); lit("R5 wrap lit", 64'd5);
    run("R5 wrap inf", 64'h7FF0000000000000, 0, 2, 4, 0, 0);
    run("R5 wrap 2^64", 64'h43F0000000000000, 0, 3, 4, 0, 0);
    // R6 illegal
    run("R6 mode6", 64'h3FF0000000000000, 0, 2, 6, 0, 0);
    run("R6 mode7", 64'h7FF0000000000001, 0, 0, 7, 0, 1);
    // R7/R9/R10 trap enabled, inexact
    run("R9 trap nan", 64'h7FF0000000000001, 0, 1, 2, 0, 1);
    run("R8 inexact 0.5 ceil", 64'h3FE0000000000000, 0, 1, 0, 2'b10, 0);
    run("R10 exact no ovf", 64'h4000000000000000, 0, 2, 0, 0, 1);
    // R11 single ignores low fraction bits
    run("R11 single", 64'h3FF000001FFFFFFF, 1, 2, 0, 2'b10, 0); lit("R11 single lit", 64'd1);
    // random mix covering R1 R2 R3 R4 R5 R7 R8 R10 R11
    for (int i = 0; i < 600; i++) begin
      v = {$urandom, $urandom};
      if ($urandom % 4 != 0) v[62:52] = 11'd1013 + 11'($urandom % 80);
      if ($urandom % 16 == 0) v[62:52] = 11'h7FF;
      run("R1 R5 random", v, 1'($urandom), 2'($urandom), 3'($urandom % 7), 2'($urandom), 1'($urandom));
    end
    @(negedge clk);
    checks++;
    if (out_valid) begin errors++; $display("FAIL R12: out_valid actual=1 expected=0"); end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule